// File: doc/BRIEF.md
# Double-Rank Crosspoint Configuration Controller

This block holds the routing state of a 33-input by 17-output digital crosspoint and performs the per-output input selection. A parallel control port with active-low strobes programs it. Each output owns a staged word and an active word. Staged words can be loaded one output at a time. A single update strobe then copies all of them into the active rank, so every connection changes on the same clock edge. A transparent mode writes the active rank directly, and a broadcast address reaches every output at once.

All strobes are sampled on a system clock, and a write or an update acts once, on the edge where its strobe is first seen low. The active words can be read back on a bus that is modelled as a data value plus a drive enable. A level-sensitive clear input disables every output. Each output also reports through a per-output indication whether it is tri-stated.

Top module: `xpt_cfg_ctrl`

## Requirements
- R1: A configuration word holds the output enable in bit 6 and the selected input number in bits 5:0. When an output's active word is enabled and carries an input number from 0 to 32, `sig_o[j]` equals `sig_i[number]`.
- R2: When an output's active enable bit is 0, `sig_o[j]` is 0 and `sig_hiz_o[j]` is 1. When the enable bit is 1, `sig_hiz_o[j]` is 0.
- R3: An enabled output whose active input number is 33 or more drives 0.
- R4: With `cs_ni` low and `upd_ni` high, a falling edge of `we_ni` stores `data_i` into the staged word of the addressed output only. No active word changes.
- R5: With `cs_ni` low and `we_ni` high, a falling edge of `upd_ni` copies all 17 staged words into the active rank on one clock edge.
- R6: With `cs_ni` low, when `we_ni` and `upd_ni` are both low and one of them has just fallen, `data_i` is stored directly into the active word of the addressed output. The staged words are left unchanged.
- R7: Address 17 (binary 10001) is the broadcast address. A staged or a transparent write to it stores the same word into all 17 outputs.
- R8: A write to an address from 18 to 31 changes no staged word and no active word.
- R9: With `cs_ni` and `re_ni` both low, `data_oe_o` is 1. `data_o` then shows the active word of the addressed output, or all zeros for address 17 or above. Otherwise `data_oe_o` is 0.
- R10: While `cs_ni` is high, the write and update strobes have no effect and the bus is not driven.
- R11: A strobe that is held low acts only on the edge where it is first sampled low. Changes to the data or address while it stays low are not stored.
- R12: While `clr_ni` is low, every active enable bit clears to 0 on the next clock edge whatever the other control inputs are. The active input numbers are kept.
- R13: `rst_ni` low asynchronously clears both ranks of every output to all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cs_ni | input | 1 | Active-low chip select |
| we_ni | input | 1 | Active-low staged write strobe |
| re_ni | input | 1 | Active-low readback strobe |
| upd_ni | input | 1 | Active-low global update strobe |
| clr_ni | input | 1 | Active-low clear of all output enables |
| addr_i | input | 5 | Output address (17 = broadcast) |
| data_i | input | 7 | Write data: enable in bit 6, input number in bits 5:0 |
| data_o | output | 7 | Readback data |
| data_oe_o | output | 1 | Readback drive enable |
| sig_i | input | 33 | Crosspoint data inputs |
| sig_o | output | 17 | Crosspoint data outputs |
| sig_hiz_o | output | 17 | Per-output tri-state indication |

## Verification
A corrupted active word shows at once on `sig_o` and `sig_hiz_o`, because those are combinational from the active rank. Sweeping a walking one across all 33 inputs exposes any wrong input number on the first pattern that hits it. A corrupted staged word stays hidden until the next update strobe, or forever if a transparent write overwrites that output first. For that reason the bench follows every staged write with an update and a full readback of all 17 outputs. An edge detector that fires more than once shows as the last value presented while a strobe is held low, rather than the first, and appears in the readback that follows the next update.

// File: rtl/xpt_pkg.sv
package xpt_pkg;
  localparam int unsigned XPT_N_IN  = 33;
  localparam int unsigned XPT_N_OUT = 17;

  // decoded control actions for one clock edge
  typedef struct packed {
    logic wr_stage;
    logic wr_active;
    logic upd_all;
  } xpt_act_t;
endpackage

// File: rtl/xpt_strobe_sync.sv
module xpt_strobe_sync
  import xpt_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     cs_ni,
  input  logic     we_ni,
  input  logic     upd_ni,
  output xpt_act_t act_o
);
  logic we_q, upd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      we_q  <= 1'b1;
      upd_q <= 1'b1;
    end else begin
      we_q  <= we_ni;
      upd_q <= upd_ni;
    end
  end

  logic we_fall, upd_fall, sel;
  assign we_fall  = we_q & ~we_ni;
  assign upd_fall = upd_q & ~upd_ni;
  assign sel      = ~cs_ni;

  always_comb begin
    act_o.wr_stage  = sel & we_fall & upd_ni;
    act_o.upd_all   = sel & upd_fall & we_ni;
    // transparent: both low, triggered by whichever fell last
    act_o.wr_active = sel & ~we_ni & ~upd_ni & (we_fall | upd_fall);
  end
endmodule

// File: rtl/xpt_rank_bank.sv
module xpt_rank_bank
  import xpt_pkg::*;
#(
  parameter int unsigned N_OUT  = XPT_N_OUT,
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned WORD_W = 7
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  xpt_act_t                     act_i,
  input  logic                         clr_ni,
  input  logic [ADDR_W-1:0]            addr_i,
  input  logic [WORD_W-1:0]            data_i,
  output logic [N_OUT-1:0][WORD_W-1:0] active_o
);
  localparam int unsigned EN_BIT = WORD_W - 1;
  localparam logic [ADDR_W-1:0] BCAST = ADDR_W'(N_OUT);

  for (genvar j = 0; j < N_OUT; j++) begin : g_out
    logic [WORD_W-1:0] stage_q, active_q;
    logic hit;
    assign hit = (addr_i == ADDR_W'(j)) || (addr_i == BCAST);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        stage_q  <= '0;
        active_q <= '0;
      end else begin
        if (act_i.wr_stage && hit) stage_q <= data_i;
        if (act_i.upd_all) active_q <= stage_q;
        else if (act_i.wr_active && hit) active_q <= data_i;
        if (!clr_ni) active_q[EN_BIT] <= 1'b0;
      end
    end

    assign active_o[j] = active_q;
  end
endmodule

// File: rtl/xpt_out_mux.sv
module xpt_out_mux #(
  parameter int unsigned N_IN   = 33,
  parameter int unsigned WORD_W = 7
) (
  input  logic [N_IN-1:0]   sig_i,
  input  logic [WORD_W-1:0] word_i,
  output logic              sig_o,
  output logic              hiz_o
);
  localparam int unsigned SEL_W = WORD_W - 1;

  logic [SEL_W-1:0] code;
  logic             pick;
  assign code = word_i[SEL_W-1:0];

  always_comb begin
    pick = 1'b0;
    for (int k = 0; k < int'(N_IN); k++)
      if (code == SEL_W'(k)) pick = sig_i[k];
  end

  assign sig_o = word_i[WORD_W-1] & pick;
  assign hiz_o = ~word_i[WORD_W-1];
endmodule

// File: rtl/xpt_cfg_ctrl.sv
module xpt_cfg_ctrl
  import xpt_pkg::*;
#(
  parameter int unsigned N_IN   = XPT_N_IN,
  parameter int unsigned N_OUT  = XPT_N_OUT,
  localparam int unsigned SEL_W  = $clog2(N_IN),
  localparam int unsigned WORD_W = SEL_W + 1,
  localparam int unsigned ADDR_W = $clog2(N_OUT + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              we_ni,
  input  logic              re_ni,
  input  logic              upd_ni,
  input  logic              clr_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [WORD_W-1:0] data_i,
  output logic [WORD_W-1:0] data_o,
  output logic              data_oe_o,
  input  logic [N_IN-1:0]   sig_i,
  output logic [N_OUT-1:0]  sig_o,
  output logic [N_OUT-1:0]  sig_hiz_o
);
  xpt_act_t act;
  logic [N_OUT-1:0][WORD_W-1:0] active;

  xpt_strobe_sync u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .cs_ni (cs_ni),
    .we_ni (we_ni),
    .upd_ni(upd_ni),
    .act_o (act)
  );

  xpt_rank_bank #(.N_OUT(N_OUT), .ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_bank (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .act_i   (act),
    .clr_ni  (clr_ni),
    .addr_i  (addr_i),
    .data_i  (data_i),
    .active_o(active)
  );

  for (genvar j = 0; j < N_OUT; j++) begin : g_mux
    xpt_out_mux #(.N_IN(N_IN), .WORD_W(WORD_W)) u_mux (
      .sig_i (sig_i),
      .word_i(active[j]),
      .sig_o (sig_o[j]),
      .hiz_o (sig_hiz_o[j])
    );
  end

  // readback; broadcast and reserved addresses match no output
  always_comb begin
    data_o = '0;
    for (int j = 0; j < int'(N_OUT); j++)
      if (addr_i == ADDR_W'(j)) data_o = active[j];
  end
  assign data_oe_o = ~cs_ni & ~re_ni;
endmodule

// File: rtl/xpt_cfg_ctrl_chk.sv
module xpt_cfg_ctrl_chk #(
  parameter int unsigned N_IN   = 33,
  parameter int unsigned N_OUT  = 17,
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned WORD_W = 7
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cs_ni,
  input logic              we_ni,
  input logic              re_ni,
  input logic              upd_ni,
  input logic              clr_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic [WORD_W-1:0] data_o,
  input logic              data_oe_o,
  input logic [N_IN-1:0]   sig_i,
  input logic [N_OUT-1:0]  sig_o,
  input logic [N_OUT-1:0]  sig_hiz_o
);
  // R12
  clear_disables_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_ni |=> &sig_hiz_o);

  // R10
  idle_holds_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_ni && clr_ni) |=> $stable(sig_hiz_o));

  // R4
  stage_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_ni && upd_ni && clr_ni && addr_i < ADDR_W'(N_OUT + 1)) |=> $stable(sig_hiz_o));

  // R9
  rb_reserved_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_ni && !re_ni && addr_i >= ADDR_W'(N_OUT)) |-> (data_oe_o && data_o == '0));

  // R2
  hiz_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sig_o & sig_hiz_o) == '0);

  // R10
  bus_released_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_ni |-> !data_oe_o);
endmodule

bind xpt_cfg_ctrl xpt_cfg_ctrl_chk #(
  .N_IN(N_IN), .N_OUT(N_OUT), .ADDR_W(ADDR_W), .WORD_W(WORD_W)
) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .cs_ni    (cs_ni),
  .we_ni    (we_ni),
  .re_ni    (re_ni),
  .upd_ni   (upd_ni),
  .clr_ni   (clr_ni),
  .addr_i   (addr_i),
  .data_o   (data_o),
  .data_oe_o(data_oe_o),
  .sig_i    (sig_i),
  .sig_o    (sig_o),
  .sig_hiz_o(sig_hiz_o)
);

// File: tb/xpt_cfg_ctrl_test.sv
module xpt_cfg_ctrl_test;
  localparam int PERIOD = 10;
  localparam int NI = 33;
  localparam int NO = 17;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic cs_ni = 1'b1, we_ni = 1'b1, re_ni = 1'b1, upd_ni = 1'b1, clr_ni = 1'b1;
  logic [4:0] addr = '0;
  logic [6:0] din = '0;
  logic [6:0] dout;
  logic dout_oe;
  logic [NI-1:0] sig_i = '0;
  logic [NO-1:0] sig_o, sig_hiz;

  int checks = 0;
  int errors = 0;

  logic [6:0] stg [NO];
  logic [6:0] act [NO];

  always #(PERIOD/2) clk = ~clk;

  xpt_cfg_ctrl uut (
    .clk_i(clk), .rst_ni(rst_ni), .cs_ni(cs_ni), .we_ni(we_ni), .re_ni(re_ni),
    .upd_ni(upd_ni), .clr_ni(clr_ni), .addr_i(addr), .data_i(din),
    .data_o(dout), .data_oe_o(dout_oe), .sig_i(sig_i), .sig_o(sig_o),
    .sig_hiz_o(sig_hiz)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, got, exp);
    end
  endtask

  task automatic check_outs(input string req);
    logic [NO-1:0] eo, eh;
    for (int j = 0; j < NO; j++) begin
      eh[j] = ~act[j][6];
      eo[j] = act[j][6] && act[j][5:0] < 6'd33 ? sig_i[act[j][5:0]] : 1'b0;
    end
    chk(sig_o == eo, {req, " sig_o"}, 64'(sig_o), 64'(eo));
    chk(sig_hiz == eh, {req, " sig_hiz_o"}, 64'(sig_hiz), 64'(eh));
  endtask

  // walking one over every input, then random words
  task automatic sweep(input string req);
    for (int p = 0; p < NI + 4; p++) begin
      sig_i = p < NI ? (NI'(1) << p) : {$urandom, $urandom};
      #1;
      check_outs(req);
    end
  endtask

  task automatic read_one(input logic [4:0] a, input logic [6:0] exp, input string req);
    @(negedge clk);
    cs_ni = 1'b0; re_ni = 1'b0; addr = a;
    #1;
    chk(dout_oe == 1'b1, {req, " readback oe"}, 64'(dout_oe), 64'd1);
    chk(dout == exp, {req, " readback data"}, 64'(dout), 64'(exp));
    re_ni = 1'b1; cs_ni = 1'b1;
  endtask

  task automatic read_all(input string req);
    for (int j = 0; j < NO; j++) read_one(5'(j), act[j], req);
  endtask

  task automatic wr(input logic [4:0] a, input logic [6:0] d);
    @(negedge clk);
    cs_ni = 1'b0; we_ni = 1'b0; addr = a; din = d;
    @(negedge clk);
    we_ni = 1'b1; cs_ni = 1'b1;
    if (a == 5'd17) for (int j = 0; j < NO; j++) stg[j] = d;
    else if (a < 5'd17) stg[a] = d;
  endtask

  task automatic upd();
    @(negedge clk);
    cs_ni = 1'b0; upd_ni = 1'b0;
    @(negedge clk);
    upd_ni = 1'b1; cs_ni = 1'b1;
    for (int j = 0; j < NO; j++) act[j] = stg[j];
  endtask

  task automatic twr(input logic [4:0] a, input logic [6:0] d);
    @(negedge clk);
    cs_ni = 1'b0; we_ni = 1'b0; upd_ni = 1'b0; addr = a; din = d;
    @(negedge clk);
    we_ni = 1'b1; upd_ni = 1'b1; cs_ni = 1'b1;
    if (a == 5'd17) for (int j = 0; j < NO; j++) act[j] = d;
    else if (a < 5'd17) act[a] = d;
  endtask

  initial begin
    #(PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int j = 0; j < NO; j++) begin stg[j] = '0; act[j] = '0; end
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R13 reset state, R2 all disabled
    chk(dout_oe == 1'b0, "R13 bus idle", 64'(dout_oe), 64'd0);
    check_outs("R13 reset");
    read_all("R13 reset");

    // R4 staged writes leave routing untouched
    for (int j = 0; j < NO; j++) wr(5'(j), {1'b1, 6'((j * 7 + 3) % NI)});
    check_outs("R4 staged only");
    read_all("R4 staged only");

    // R5 update, R1 selection
    upd();
    read_all("R5 update");
    sweep("R1 routing");

    // R6 transparent write bypasses staging
    twr(5'd3, {1'b1, 6'd32});
    sweep("R6 transparent");
    read_one(5'd3, 7'h60, "R6 transparent");
    upd();
    read_one(5'd3, stg[3], "R6 staged kept");

    // R3 reserved input code
    twr(5'd9, {1'b1, 6'd40});
    sweep("R3 reserved code");

    // R8 reserved addresses ignored
    for (int a = 18; a < 32; a++) wr(5'(a), 7'h45);
    for (int a = 18; a < 32; a++) twr(5'(a), 7'h00);
    check_outs("R8 reserved transparent");
    upd();
    read_all("R8 reserved staged");

    // R9 readback of broadcast and reserved addresses
    for (int a = 17; a < 32; a++) read_one(5'(a), 7'h00, "R9 reserved readback");

    // R7 broadcast staged then update
    wr(5'd17, {1'b1, 6'd5});
    check_outs("R7 broadcast staged");
    upd();
    read_all("R7 broadcast update");
    sweep("R7 broadcast routing");

    // R7 broadcast transparent disable
    twr(5'd17, {1'b0, 6'd11});
    sweep("R7 broadcast disable");
    read_all("R7 broadcast disable");

    // R11 held strobe acts once
    @(negedge clk);
    cs_ni = 1'b0; we_ni = 1'b0; addr = 5'd5; din = 7'h4a;
    @(negedge clk); din = 7'h51;
    @(negedge clk); addr = 5'd6; din = 7'h52;
    @(negedge clk); we_ni = 1'b1; cs_ni = 1'b1;
    stg[5] = 7'h4a;
    upd();
    read_one(5'd5, 7'h4a, "R11 held write");
    read_one(5'd6, stg[6], "R11 held write other");

    // R10 chip select high blocks strobes and bus
    @(negedge clk);
    cs_ni = 1'b1; we_ni = 1'b0; upd_ni = 1'b0; re_ni = 1'b0; addr = 5'd2; din = 7'h7f;
    #1;
    chk(dout_oe == 1'b0, "R10 bus undriven", 64'(dout_oe), 64'd0);
    @(negedge clk);
    we_ni = 1'b1; upd_ni = 1'b1; re_ni = 1'b1;
    check_outs("R10 ignored");
    upd();
    read_all("R10 staged untouched");

    // R12 clear keeps codes, drops enables, even with a strobe present
    for (int j = 0; j < NO; j++) twr(5'(j), {1'b1, 6'((j * 5) % NI)});
    sweep("R12 before clear");
    @(negedge clk);
    clr_ni = 1'b0; cs_ni = 1'b0; addr = 5'd4; din = 7'h41; we_ni = 1'b0; upd_ni = 1'b0;
    @(negedge clk);
    clr_ni = 1'b1; we_ni = 1'b1; upd_ni = 1'b1; cs_ni = 1'b1;
    act[4] = 7'h41;
    for (int j = 0; j < NO; j++) act[j][6] = 1'b0;
    check_outs("R12 clear");
    read_all("R12 clear");

    // R13 asynchronous reset mid-run
    twr(5'd17, 7'h47);
    check_outs("R13 before reset");
    #2;
    rst_ni = 1'b0;
    #1;
    for (int j = 0; j < NO; j++) begin act[j] = '0; stg[j] = '0; end
    check_outs("R13 async reset");
    @(negedge clk);
    rst_ni = 1'b1;
    upd();
    read_all("R13 staged cleared");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule